// File: doc/BRIEF.md
# Backlight Pulse-Width Modulator

This block generates a single pulse-width-modulated signal for a display backlight. A prescaler divides the input clock by a programmable factor of 1 to 1024. A period counter steps once per divided tick and wraps after a programmable count of 1 to 4096 ticks. The output is high while the period count is below a programmable high width, so a larger width relative to the period gives a brighter panel.

Software programs the block through a small word-addressed register port. Timing values land in shadow registers first. They reach the running generator only when the commit bit makes a 0-to-1 transition. While the output is running, the committed values are applied at the next period boundary, so a period never mixes old and new settings. While the output is off, they are applied at once. The enable bit acts directly and is not shadowed.

Top module: `bl_pwm`

## Requirements
- R1: Register map: byte offset 0x00 holds the enable bit in bit 0; offset 0x08 holds the commit bit in bit 0; offset 0x10 holds the 10-bit prescale value in bits [25:16]; offset 0x14 holds the 12-bit period in bits [11:0] and the 13-bit high width in bits [28:16]. Each field reads back what was last written to it.
- R2: Unused bits read as zero. A read of any other offset returns zero. A write to any other offset changes no register and leaves the output unaffected.
- R3: While enabled, one output period lasts (prescale+1)*(period+1) clock cycles.
- R4: Each period starts with the output high for (prescale+1)*width cycles and ends with it low for the rest of the period.
- R5: A committed width of 0 keeps the output permanently low.
- R6: A committed width of period+1 or more keeps the output permanently high.
- R7: Writing the timing registers without a commit has no effect on the output.
- R8: A 0-to-1 write of the commit bit while enabled applies the shadow values from the first period boundary after the commit write.
- R9: While disabled, the output is low, the counters rest at zero, and a commit takes effect at once. The clock cycle after the enable write begins a fresh period, and the output is high in that cycle if the width is nonzero.
- R10: Reset clears every register and counter, which leaves the output low and every register reading zero.
- R11: Writing 1 to the commit bit when it already holds 1 loads nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the same cycle as rd_i, zero otherwise |
| pwm_o | output | 1 | Backlight PWM output |

## Verification
The read data is combinational, so each read is checked 1 ns after rd_i is driven in the same cycle. The enable bit is registered, so the output reflects it from the cycle after the write edge. The bench counts that cycle as t=0 of a fresh period and compares every later cycle against a waveform computed from prescale, period and width. A commit is registered once as a pulse, so the bench sets the switch point to the first multiple of the period length after the cycle in which the commit write lands. It compares old and new waveforms on either side of that point. All samples are taken on the falling edge, so writes, loads and counter steps have settled.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;
  localparam int DIV_W   = 10;
  localparam int PER_W   = 12;
  localparam int HW_W    = 13;
  localparam int DIV_LSB = 16;
  localparam int PER_LSB = 0;
  localparam int HW_LSB  = 16;

  localparam logic [7:0] OFF_EN     = 8'h00;
  localparam logic [7:0] OFF_COMMIT = 8'h08;
  localparam logic [7:0] OFF_CFG0   = 8'h10;
  localparam logic [7:0] OFF_CFG1   = 8'h14;

  typedef struct packed {
    logic [HW_W-1:0]  hw;
    logic [PER_W-1:0] per;
    logic [DIV_W-1:0] div;
  } pwm_cfg_t;
endpackage

// File: rtl/bl_pwm_regs.sv
module bl_pwm_regs
  import bl_pwm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              en_o,
  output pwm_cfg_t          shadow_o,
  output logic              load_o
);
  logic     en_q, commit_q, load_q;
  pwm_cfg_t sh_q;

  logic sel_en, sel_commit, sel_cfg0, sel_cfg1;
  assign sel_en     = addr_i == ADDR_W'(OFF_EN);
  assign sel_commit = addr_i == ADDR_W'(OFF_COMMIT);
  assign sel_cfg0   = addr_i == ADDR_W'(OFF_CFG0);
  assign sel_cfg1   = addr_i == ADDR_W'(OFF_CFG1);

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      commit_q <= 1'b0;
      load_q   <= 1'b0;
      sh_q     <= '0;
    end else begin
      // one-cycle load request on a 0->1 commit transition only
      load_q <= wr_i && sel_commit && wdata_i[0] && !commit_q;
      if (wr_i) begin
        if (sel_en)     en_q     <= wdata_i[0];
        if (sel_commit) commit_q <= wdata_i[0];
        if (sel_cfg0)   sh_q.div <= wdata_i[DIV_LSB +: DIV_W];
        if (sel_cfg1) begin
          sh_q.per <= wdata_i[PER_LSB +: PER_W];
          sh_q.hw  <= wdata_i[HW_LSB +: HW_W];
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if (sel_en)     rdata_o[0] = en_q;
      if (sel_commit) rdata_o[0] = commit_q;
      if (sel_cfg0)   rdata_o[DIV_LSB +: DIV_W] = sh_q.div;
      if (sel_cfg1) begin
        rdata_o[PER_LSB +: PER_W] = sh_q.per;
        rdata_o[HW_LSB +: HW_W]   = sh_q.hw;
      end
    end
  end

  assign en_o     = en_q;
  assign shadow_o = sh_q;
  assign load_o   = load_q;

  // R11: a load request only follows a fresh 0->1 transition of the commit bit
  a_r11_commit_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_q |-> (commit_q && !$past(commit_q)));

  // R2: an undefined offset never returns data
  a_r2_undef_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_en && !sel_commit && !sel_cfg0 && !sel_cfg1) |-> (rdata_o == '0));
endmodule

// File: rtl/bl_pwm_timer.sv
module bl_pwm_timer
  import bl_pwm_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  logic     load_i,
  input  pwm_cfg_t shadow_i,
  output logic     pwm_o
);
  pwm_cfg_t         act_q;
  logic             pend_q;
  logic [DIV_W-1:0] pre_q;
  logic [PER_W-1:0] per_q;

  logic tick, period_end, take;
  assign tick       = pre_q == act_q.div;
  assign period_end = tick && (per_q == act_q.per);
  assign take       = load_i || pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= '0;
      pend_q <= 1'b0;
      pre_q  <= '0;
      per_q  <= '0;
    end else if (!en_i) begin
      pre_q <= '0;
      per_q <= '0;
      if (take) begin
        act_q  <= shadow_i;
        pend_q <= 1'b0;
      end
    end else begin
      if (tick) begin
        pre_q <= '0;
        per_q <= period_end ? '0 : per_q + PER_W'(1);
      end else begin
        pre_q <= pre_q + DIV_W'(1);
      end
      if (period_end && take) begin
        act_q  <= shadow_i;
        pend_q <= 1'b0;
      end else if (load_i) begin
        pend_q <= 1'b1;
      end
    end
  end

  // width is one bit wider than the period so full-on is expressible
  assign pwm_o = en_i && ({1'b0, per_q} < act_q.hw);

  a_r9_idle_counters: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (pre_q == '0 && per_q == '0));

  a_r3_pre_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_q <= act_q.div);

  a_r3_per_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_q <= act_q.per);

  a_r8_hold_midperiod: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !period_end) |=> $stable(act_q));

  a_r6_full_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && (act_q.hw > {1'b0, act_q.per})) |-> pwm_o);

  a_r5_zero_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q.hw == '0) |-> !pwm_o);
endmodule

// File: rtl/bl_pwm.sv
module bl_pwm
  import bl_pwm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              pwm_o
);
  logic     en, load;
  pwm_cfg_t shadow;

  bl_pwm_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_i),
    .rd_i     (rd_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .en_o     (en),
    .shadow_o (shadow),
    .load_o   (load)
  );

  bl_pwm_timer u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en),
    .load_i   (load),
    .shadow_i (shadow),
    .pwm_o    (pwm_o)
  );

  a_r10_off_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> !pwm_o);
endmodule

// File: tb/bl_pwm_test.sv
`timescale 1ns/1ps
module bl_pwm_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pwm;

  int errs = 0;
  int checks = 0;
  int tcur = 0;

  localparam logic [7:0] A_EN = 8'h00, A_CM = 8'h08, A_C0 = 8'h10, A_C1 = 8'h14;

  always #5 clk = ~clk;

  bl_pwm uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_i(wr), .rd_i(rd),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    tcur++;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
    addr = a; rd = 1'b1;
    #1;
    chk(req, rdata, exp);
    rd = 1'b0;
  endtask

  function automatic logic exp_pwm(int t, int d, int p, int h);
    int len = (d + 1) * (p + 1);
    int ph  = (t % len) / (d + 1);
    return ph < h;
  endfunction

  // compare n cycles; width switches from h_old to h_new at cycle nb
  task automatic run_cmp(input int n, input int d, input int p, input int h_old,
                         input int h_new, input int nb, input string req);
    int mism = 0;
    int bad_t = -1;
    for (int i = 0; i < n; i++) begin
      int h = (tcur < nb) ? h_old : h_new;
      if (pwm !== exp_pwm(tcur, d, p, h)) begin
        mism++;
        if (bad_t < 0) bad_t = tcur;
      end
      @(negedge clk);
      tcur++;
    end
    if (mism != 0) $display("  first mismatch at t=%0d (d=%0d p=%0d)", bad_t, d, p);
    chk(req, mism, 0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL R3 watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    int nb;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk("R10 pwm", pwm, 0);
    rd_chk(A_EN, 0, "R10 en");
    rd_chk(A_CM, 0, "R10 commit");
    rd_chk(A_C0, 0, "R10 cfg0");
    rd_chk(A_C1, 0, "R10 cfg1");

    // R1 field placement, R2 unused bits
    wr_reg(A_C0, 32'hFFFF_FFFF);
    rd_chk(A_C0, 32'h03FF_0000, "R1 cfg0");
    wr_reg(A_C1, 32'hFFFF_FFFF);
    rd_chk(A_C1, 32'h1FFF_0FFF, "R1 cfg1");
    wr_reg(A_CM, 32'hFFFF_FFFF);
    rd_chk(A_CM, 32'h0000_0001, "R1 commit");

    // R2 undefined offsets
    wr_reg(8'h04, 32'hFFFF_FFFF);
    wr_reg(8'h0C, 32'hFFFF_FFFF);
    wr_reg(8'h18, 32'h0000_0001);
    rd_chk(8'h04, 0, "R2 undef read");
    rd_chk(8'h0C, 0, "R2 undef read");
    rd_chk(A_EN, 0, "R2 en untouched");
    rd_chk(A_C0, 32'h03FF_0000, "R2 cfg0 untouched");
    chk("R2 pwm stays low", pwm, 0);

    wr_reg(A_EN, 32'h0000_0001);
    rd_chk(A_EN, 32'h0000_0001, "R1 en");

    // sweep: R3 R4 R5 R6 R9
    for (int d = 0; d < 3; d++)
      for (int p = 0; p < 4; p++)
        for (int h = 0; h < 6; h++) begin
          wr_reg(A_EN, 0);
          chk("R9 off low", pwm, 0);
          wr_reg(A_C0, d << 16);
          wr_reg(A_C1, (h << 16) | p);
          wr_reg(A_CM, 0);
          wr_reg(A_CM, 1);
          wr_reg(A_EN, 1);
          tcur = 0;
          chk("R9 fresh start", pwm, (h != 0) ? 1 : 0);
          if (h == 0)
            run_cmp(2 * (d + 1) * (p + 1), d, p, h, h, 0, "R5");
          else if (h >= p + 1)
            run_cmp(2 * (d + 1) * (p + 1), d, p, h, h, 0, "R6");
          else
            run_cmp(2 * (d + 1) * (p + 1), d, p, h, h, 0, "R3 R4");
        end

    // R7 / R8 / R11 with prescale 0, period 4 cycles
    wr_reg(A_EN, 0);
    wr_reg(A_C0, 0);
    wr_reg(A_C1, (1 << 16) | 3);
    wr_reg(A_CM, 0);
    wr_reg(A_CM, 1);
    wr_reg(A_EN, 1);
    tcur = 0;
    run_cmp(5, 0, 3, 1, 1, 0, "R7 baseline");
    wr_reg(A_C1, (3 << 16) | 3);
    run_cmp(8, 0, 3, 1, 1, 0, "R7 shadow only");
    wr_reg(A_CM, 0);
    wr_reg(A_CM, 1);
    nb = ((tcur / 4) + 1) * 4;
    run_cmp(12, 0, 3, 1, 3, nb, "R8 boundary");
    wr_reg(A_C1, (0 << 16) | 3);
    wr_reg(A_CM, 1);
    run_cmp(12, 0, 3, 3, 3, 0, "R11 no edge");
    wr_reg(A_CM, 0);
    wr_reg(A_CM, 1);
    nb = ((tcur / 4) + 1) * 4;
    run_cmp(12, 0, 3, 3, 0, nb, "R11 fresh edge");

    summary();
    $finish;
  end
endmodule